// File: doc/BRIEF.md
# Register Rename Unit with Retirement-Time Freeing

This block translates the architectural register numbers of one instruction per cycle into physical register numbers. Each accepted instruction has two architectural sources and one destination. The block returns the physical registers the sources currently map to. It also allocates a fresh physical register for the destination and points the destination's map entry at it. Because every write gets its own physical register, write-after-write and write-after-read hazards on architectural names disappear.

Each accepted instruction takes a slot in a circular reorder buffer. That slot records the architectural destination, the new physical register and the physical register the destination mapped to before. An execution side marks slots done by tag, and the oldest slot retires once it is done. Retirement is the only point at which the displaced physical register goes back to the free pool. The block never frees a register at rename time, because an older in-flight instruction, or one that a rollback revives, may still need the old value.

A flush squashes every slot that has not yet retired. The buffer then walks from its youngest slot to its oldest, one slot per cycle. At each step it puts the old mapping back into the map table and returns the squashed instruction's new physical register to the pool.

Top module: `rn_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i, physical registers NUM_ARCH and above are free, the buffer is empty, `ren_ready` is high and `ret_valid` is low.
- R2: The source fields `ren_psrc1` and `ren_psrc2` show the mapping that held before this instruction's own destination update. An instruction whose source equals its destination therefore reads the previous physical register.
- R3: `ren_pdst` is the lowest-numbered free physical register. Two back-to-back renames to the same architectural register receive different physical registers.
- R4: On retirement, `ret_areg` is the retiring slot's destination and `ret_pfree` is the physical register that destination mapped to before that instruction. That register becomes allocatable from the next cycle on, and never earlier.
- R5: Slots are tagged 0, 1, … DEPTH-1 in rename order and the count wraps. A slot retires only when it is the oldest and has been marked done through `done_valid`/`done_tag`, so a done younger slot does not retire ahead of an older slot that is not done.
- R6: `ren_ready` is low when no physical register is free or every buffer slot is occupied. While `ren_ready` is low, `ren_valid` changes no state.
- R7: In the cycle `flush` is high, and then for one cycle per squashed slot, `ren_ready` is low and nothing retires. During the walk `walk_busy` is high. Each step restores the youngest remaining slot's old mapping and frees its new register. Afterwards the map, the free pool and the next tag equal their values before the squashed renames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Instruction offered for renaming |
| ren_src1 | input | AREG_W | First architectural source |
| ren_src2 | input | AREG_W | Second architectural source |
| ren_dst | input | AREG_W | Architectural destination |
| ren_ready | output | 1 | Rename accepted this cycle when valid |
| ren_psrc1 | output | PREG_W | Physical register for first source |
| ren_psrc2 | output | PREG_W | Physical register for second source |
| ren_pdst | output | PREG_W | Newly allocated physical destination |
| ren_tag | output | TAG_W | Buffer slot given to this instruction |
| done_valid | input | 1 | Mark a slot as finished executing |
| done_tag | input | TAG_W | Slot to mark |
| flush | input | 1 | Squash all unretired instructions |
| walk_busy | output | 1 | Flush recovery walk in progress |
| ret_valid | output | 1 | Oldest slot retires this cycle |
| ret_areg | output | AREG_W | Destination of the retiring slot |
| ret_pfree | output | PREG_W | Physical register released by retirement |

## Verification
On every cycle the assertions check the following: no release targets a register already in the free pool; a rename never pushes into a full buffer or during a walk; and the register handed out at rename never equals the one being released in the same cycle. Some behaviours only the bench can show, because its reference model mirrors the architectural mapping over whole scenarios. These are the identity map after reset, a source reading the old mapping when it equals the destination, retirement held back by an older unfinished slot, the reuse of a freed register, and a flush restoring both the map and the pool. The bench also fills the pool until rename stalls.

// File: rtl/rn_pkg.sv
package rn_pkg;
   typedef enum logic {
      RN_RUN  = 1'b0,
      RN_WALK = 1'b1
   } rn_mode_e;
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list #(
   parameter int NUM_PHYS  = 16,
   parameter int NUM_ARCH  = 8,
   parameter bit LOW_FIRST = 1'b1,
   localparam int PW = $clog2(NUM_PHYS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          alloc_en,
   output logic [PW-1:0] alloc_idx,
   output logic          alloc_ok,
   input  logic          rel_a_en,
   input  logic [PW-1:0] rel_a_idx,
   input  logic          rel_b_en,
   input  logic [PW-1:0] rel_b_idx
);
   logic [NUM_PHYS-1:0] avail_q;

   if (NUM_PHYS <= NUM_ARCH) begin : g_bad_size
      $error("rn_free_list: NUM_PHYS must exceed NUM_ARCH");
   end

   if (LOW_FIRST) begin : g_low
      always_comb begin
         alloc_ok  = 1'b0;
         alloc_idx = '0;
         for (int i = NUM_PHYS - 1; i >= 0; i--) begin
            if (avail_q[i]) begin
               alloc_ok  = 1'b1;
               alloc_idx = PW'(i);
            end
         end
      end
   end else begin : g_high
      always_comb begin
         alloc_ok  = 1'b0;
         alloc_idx = '0;
         for (int i = 0; i < NUM_PHYS; i++) begin
            if (avail_q[i]) begin
               alloc_ok  = 1'b1;
               alloc_idx = PW'(i);
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_PHYS; i++) avail_q[i] <= (i >= NUM_ARCH);
      end else begin
         if (alloc_en) avail_q[alloc_idx] <= 1'b0;
         if (rel_a_en) avail_q[rel_a_idx] <= 1'b1;
         if (rel_b_en) avail_q[rel_b_idx] <= 1'b1;
      end
   end

   // R4: retirement never releases a register that is already free
   a_r4_no_double_free: assert property (@(posedge clk) disable iff (!rst_n)
      rel_a_en |-> !avail_q[rel_a_idx]);
   // R7: a walk step returns a register that was in use
   a_r7_walk_release_in_use: assert property (@(posedge clk) disable iff (!rst_n)
      rel_b_en |-> !avail_q[rel_b_idx]);
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
   parameter int NUM_ARCH = 8,
   parameter int NUM_PHYS = 16,
   localparam int AW = $clog2(NUM_ARCH),
   localparam int PW = $clog2(NUM_PHYS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] rd1_a,
   output logic [PW-1:0] rd1_p,
   input  logic [AW-1:0] rd2_a,
   output logic [PW-1:0] rd2_p,
   input  logic [AW-1:0] rd3_a,
   output logic [PW-1:0] rd3_p,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [PW-1:0] wd
);
   logic [PW-1:0] tbl_q [NUM_ARCH];

   assign rd1_p = tbl_q[rd1_a];
   assign rd2_p = tbl_q[rd2_a];
   assign rd3_p = tbl_q[rd3_a];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_ARCH; i++) tbl_q[i] <= PW'(i);
      end else if (we) begin
         tbl_q[wa] <= wd;
      end
   end
endmodule

// File: rtl/rn_rob.sv
module rn_rob #(
   parameter int DEPTH = 8,
   parameter int AW    = 3,
   parameter int PW    = 4,
   localparam int IW = $clog2(DEPTH),
   localparam int CW = IW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_areg,
   input  logic [PW-1:0] push_pnew,
   input  logic [PW-1:0] push_pold,
   output logic [IW-1:0] tail_idx,
   output logic          full,
   input  logic          cpl_valid,
   input  logic [IW-1:0] cpl_idx,
   input  logic          flush,
   output logic          pop_valid,
   output logic [AW-1:0] pop_areg,
   output logic [PW-1:0] pop_pold,
   output logic          walking,
   output logic [AW-1:0] walk_areg,
   output logic [PW-1:0] walk_pnew,
   output logic [PW-1:0] walk_pold
);
   import rn_pkg::*;

   if ((1 << IW) != DEPTH || DEPTH < 2) begin : g_bad_depth
      $error("rn_rob: DEPTH must be a power of two, at least 2");
   end

   logic [AW-1:0]    areg_q [DEPTH];
   logic [PW-1:0]    pnew_q [DEPTH];
   logic [PW-1:0]    pold_q [DEPTH];
   logic [DEPTH-1:0] done_q;
   logic [IW-1:0]    head_q, tail_q, last;
   logic [CW-1:0]    count_q;
   rn_mode_e         mode_q;

   assign walking   = (mode_q == RN_WALK);
   assign tail_idx  = tail_q;
   assign full      = (count_q == CW'(DEPTH));
   assign last      = tail_q - IW'(1);
   assign pop_valid = !walking && !flush && (count_q != '0) && done_q[head_q];
   assign pop_areg  = areg_q[head_q];
   assign pop_pold  = pold_q[head_q];
   assign walk_areg = areg_q[last];
   assign walk_pnew = pnew_q[last];
   assign walk_pold = pold_q[last];

   always_ff @(posedge clk) begin
      if (push) begin
         areg_q[tail_q] <= push_areg;
         pnew_q[tail_q] <= push_pnew;
         pold_q[tail_q] <= push_pold;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
         done_q  <= '0;
         mode_q  <= RN_RUN;
      end else if (walking) begin
         tail_q  <= last;
         count_q <= count_q - CW'(1);
         if (count_q == CW'(1)) mode_q <= RN_RUN;
      end else begin
         if (flush && count_q != '0) mode_q <= RN_WALK;
         if (cpl_valid) done_q[cpl_idx] <= 1'b1;
         if (push) begin
            done_q[tail_q] <= 1'b0;
            tail_q         <= tail_q + IW'(1);
         end
         if (pop_valid) head_q <= head_q + IW'(1);
         count_q <= count_q + CW'(push) - CW'(pop_valid);
      end
   end

   // R6: no rename is pushed into a full buffer
   a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (count_q < CW'(DEPTH)));
   // R7: renaming is held off while the walk runs
   a_r7_walk_blocks_push: assert property (@(posedge clk) disable iff (!rst_n)
      walking |-> !push);
endmodule

// File: rtl/rn_rename.sv
module rn_rename #(
   parameter int NUM_ARCH  = 8,
   parameter int NUM_PHYS  = 16,
   parameter int ROB_DEPTH = 8,
   parameter bit LOW_FIRST = 1'b1,
   localparam int AREG_W = $clog2(NUM_ARCH),
   localparam int PREG_W = $clog2(NUM_PHYS),
   localparam int TAG_W  = $clog2(ROB_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ren_valid,
   input  logic [AREG_W-1:0] ren_src1,
   input  logic [AREG_W-1:0] ren_src2,
   input  logic [AREG_W-1:0] ren_dst,
   output logic              ren_ready,
   output logic [PREG_W-1:0] ren_psrc1,
   output logic [PREG_W-1:0] ren_psrc2,
   output logic [PREG_W-1:0] ren_pdst,
   output logic [TAG_W-1:0]  ren_tag,
   input  logic              done_valid,
   input  logic [TAG_W-1:0]  done_tag,
   input  logic              flush,
   output logic              walk_busy,
   output logic              ret_valid,
   output logic [AREG_W-1:0] ret_areg,
   output logic [PREG_W-1:0] ret_pfree
);
   logic              fire, alloc_ok, rob_full, walking;
   logic [PREG_W-1:0] alloc_idx, prev_map, walk_pnew, walk_pold;
   logic [AREG_W-1:0] walk_areg;
   logic              map_we;
   logic [AREG_W-1:0] map_wa;
   logic [PREG_W-1:0] map_wd;

   assign ren_ready = alloc_ok && !rob_full && !walking && !flush;
   assign fire      = ren_valid && ren_ready;
   assign ren_pdst  = alloc_idx;
   assign walk_busy = walking;

   assign map_we = fire || walking;
   assign map_wa = walking ? walk_areg : ren_dst;
   assign map_wd = walking ? walk_pold : alloc_idx;

   rn_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_map (
      .clk   (clk),
      .rst_n (rst_n),
      .rd1_a (ren_src1),
      .rd1_p (ren_psrc1),
      .rd2_a (ren_src2),
      .rd2_p (ren_psrc2),
      .rd3_a (ren_dst),
      .rd3_p (prev_map),
      .we    (map_we),
      .wa    (map_wa),
      .wd    (map_wd)
   );

   rn_free_list #(.NUM_PHYS(NUM_PHYS), .NUM_ARCH(NUM_ARCH), .LOW_FIRST(LOW_FIRST)) u_free (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_en  (fire),
      .alloc_idx (alloc_idx),
      .alloc_ok  (alloc_ok),
      .rel_a_en  (ret_valid),
      .rel_a_idx (ret_pfree),
      .rel_b_en  (walking),
      .rel_b_idx (walk_pnew)
   );

   rn_rob #(.DEPTH(ROB_DEPTH), .AW(AREG_W), .PW(PREG_W)) u_rob (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (fire),
      .push_areg (ren_dst),
      .push_pnew (alloc_idx),
      .push_pold (prev_map),
      .tail_idx  (ren_tag),
      .full      (rob_full),
      .cpl_valid (done_valid),
      .cpl_idx   (done_tag),
      .flush     (flush),
      .pop_valid (ret_valid),
      .pop_areg  (ret_areg),
      .pop_pold  (ret_pfree),
      .walking   (walking),
      .walk_areg (walk_areg),
      .walk_pnew (walk_pnew),
      .walk_pold (walk_pold)
   );

   // R4: the register released by retirement is never handed out in the same cycle
   a_r4_release_not_alloc: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && ret_valid) |-> (alloc_idx != ret_pfree));
   // R7: nothing retires while a flush or its walk is in progress
   a_r7_no_retire_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (flush || walk_busy) |-> !ret_valid);
endmodule

// File: tb/rn_rename_test.sv
module rn_rename_test;
   localparam int NA = 8;
   localparam int NP = 16;
   localparam int ND = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ren_valid = 1'b0;
   logic [2:0] ren_src1 = '0, ren_src2 = '0, ren_dst = '0;
   logic       ren_ready;
   logic [3:0] ren_psrc1, ren_psrc2, ren_pdst;
   logic [2:0] ren_tag;
   logic       done_valid = 1'b0;
   logic [2:0] done_tag = '0;
   logic       flush = 1'b0;
   logic       walk_busy, ret_valid;
   logic [2:0] ret_areg;
   logic [3:0] ret_pfree;

   always #4 clk = ~clk;

   rn_rename uut (.*);

   typedef struct {int areg; int pnew; int pold; int idx; bit done;} ent_t;
   ent_t q[$];
   int   mmap[NA];
   bit   mfree[NP];
   int   mtail, nchk, nfail;
   bit   mwalk;

   task automatic chk(string tag, string what, int act, int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic int lowest_free();
      for (int i = 0; i < NP; i++) if (mfree[i]) return i;
      return -1;
   endfunction

   task automatic drive(bit v, int s1, int s2, int d, bit cv, int ci, bit fl);
      ren_valid = v; ren_src1 = 3'(s1); ren_src2 = 3'(s2); ren_dst = 3'(d);
      done_valid = cv; done_tag = 3'(ci); flush = fl;
      #1;
   endtask

   // compare against the reference model, advance it by one edge
   task automatic tick();
      int  lf = lowest_free();
      bit  rdy = !flush && !mwalk && q.size() < ND && lf >= 0;
      bit  cv = !mwalk && !flush && q.size() > 0 && q[0].done;
      bit  fire = ren_valid && rdy;
      chk("R6", "ren_ready", ren_ready, rdy);
      chk("R7", "walk_busy", walk_busy, mwalk);
      chk("R5", "ret_valid", ret_valid, cv);
      if (rdy) begin
         chk("R2", "psrc1", ren_psrc1, mmap[ren_src1]);
         chk("R2", "psrc2", ren_psrc2, mmap[ren_src2]);
         chk("R3", "pdst", ren_pdst, lf);
         chk("R5", "tag", ren_tag, mtail);
      end
      if (cv) begin
         chk("R4", "ret_pfree", ret_pfree, q[0].pold);
         chk("R4", "ret_areg", ret_areg, q[0].areg);
      end
      if (mwalk) begin
         ent_t e = q.pop_back();
         mmap[e.areg] = e.pold;
         mfree[e.pnew] = 1'b1;
         mtail = (mtail + ND - 1) % ND;
         if (q.size() == 0) mwalk = 1'b0;
      end else begin
         if (flush && q.size() > 0) mwalk = 1'b1;
         if (done_valid)
            foreach (q[k]) if (q[k].idx == done_tag) q[k].done = 1'b1;
         if (cv) begin
            mfree[q[0].pold] = 1'b1;
            void'(q.pop_front());
         end
         if (fire) begin
            mfree[lf] = 1'b0;
            q.push_back('{int'(ren_dst), lf, mmap[ren_dst], mtail, 1'b0});
            mmap[ren_dst] = lf;
            mtail = (mtail + 1) % ND;
         end
      end
      @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end

   initial begin
      for (int i = 0; i < NA; i++) mmap[i] = i;
      for (int i = 0; i < NP; i++) mfree[i] = (i >= NA);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      drive(0, 0, 0, 0, 0, 0, 0);
      chk("R1", "ren_ready after reset", ren_ready, 1);
      chk("R1", "ret_valid after reset", ret_valid, 0);
      tick();
      // A: identity map, first free register is NUM_ARCH
      drive(1, 3, 5, 3, 0, 0, 0);
      chk("R1", "psrc1 identity", ren_psrc1, 3);
      chk("R1", "psrc2 identity", ren_psrc2, 5);
      chk("R3", "first pdst", ren_pdst, 8);
      tick();
      // B: source equals destination reads old mapping, fresh dest
      drive(1, 3, 3, 3, 0, 0, 0);
      chk("R2", "src sees previous map", ren_psrc1, 8);
      chk("R3", "distinct back-to-back pdst", ren_pdst, 9);
      tick();
      // C/D: younger done first must not retire
      drive(0, 0, 0, 0, 1, 1, 0);
      chk("R5", "no retire, head not done", ret_valid, 0);
      tick();
      drive(0, 0, 0, 0, 1, 0, 0);
      chk("R5", "younger done does not retire", ret_valid, 0);
      tick();
      drive(0, 0, 0, 0, 0, 0, 0);
      chk("R4", "retire oldest", ret_valid, 1);
      chk("R4", "frees old map of r3", ret_pfree, 3);
      tick();
      drive(0, 0, 0, 0, 0, 0, 0);
      chk("R4", "second retire frees p8", ret_pfree, 8);
      tick();
      drive(1, 0, 0, 1, 0, 0, 0);
      chk("R4", "freed register reused", ren_pdst, 3);
      tick();
      drive(1, 3, 1, 2, 0, 0, 0);
      chk("R2", "psrc1 after renames", ren_psrc1, 9);
      chk("R2", "psrc2 after renames", ren_psrc2, 3);
      chk("R3", "next lowest", ren_pdst, 8);
      tick();
      // flush with two in flight
      drive(1, 0, 0, 0, 0, 0, 1);
      chk("R7", "ready low on flush", ren_ready, 0);
      tick();
      drive(1, 0, 0, 0, 0, 0, 0);
      chk("R7", "walk busy step 1", walk_busy, 1);
      chk("R7", "ready low in walk", ren_ready, 0);
      tick();
      drive(1, 0, 0, 0, 0, 0, 0);
      chk("R7", "walk busy step 2", walk_busy, 1);
      tick();
      drive(1, 1, 2, 4, 0, 0, 0);
      chk("R7", "walk ended", walk_busy, 0);
      chk("R7", "r1 map restored", ren_psrc1, 1);
      chk("R7", "r2 map restored", ren_psrc2, 2);
      chk("R7", "freed pdst restored", ren_pdst, 3);
      chk("R7", "tag rewound", ren_tag, 2);
      tick();
      // exhaust free registers and slots
      for (int n = 0; n < 7; n++) begin
         drive(1, n, 7 - n, 5, 0, 0, 0);
         tick();
      end
      drive(1, 1, 1, 6, 0, 0, 0);
      chk("R6", "stall when exhausted", ren_ready, 0);
      tick();
      // mixed traffic
      for (int c = 0; c < 1500; c++) begin
         bit fl = 0, cv = 0;
         int ci = 0;
         if (!mwalk && q.size() > 0 && ($urandom % 40) == 0) fl = 1;
         if (!mwalk && !fl && ($urandom % 5) < 3) begin
            int cand[$];
            foreach (q[k]) if (!q[k].done) cand.push_back(q[k].idx);
            if (cand.size() > 0) begin
               cv = 1;
               ci = cand[$urandom % cand.size()];
            end
         end
         drive(($urandom % 4) != 0, $urandom % NA, $urandom % NA, $urandom % NA, cv, ci, fl);
         tick();
      end
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end
endmodule